// File: doc/BRIEF.md
# Mouse Interrupt Edge Latch

This block sits between a shared interrupt input pin and the IRQ12 request line of the system interrupt controller. A mode bit, owned by a configuration register outside the block, selects between two behaviours. In pass-through mode the synchronized pin level is forwarded unchanged as IRQ12. In mouse mode a low-to-high transition on the pin sets a sticky latch. That latch drives IRQ12 until either a bus reset or an I/O read of the keyboard data port (address 0x060) clears it.

The pin has a weak pull-up, so an undriven pin reads as high. The block first passes the pin through a multi-stage synchronizer. It then finds rising edges by comparing the newest synchronized sample with the one before it. A small decoder sorts each I/O strobe into one of four classes: data-port read, data-port write, other access, or no access. Only a data-port read clears the latch. When a rising edge and a clearing read fall in the same cycle, the edge wins.

Top module: `mouse_irq_latch`

## Requirements
- R1: While `rst` is high at a clock edge, the latch clears and every synchronizer stage loads 1, so IRQ12 is low in mouse mode after reset and no false edge appears from the reset state.
- R2: In mouse mode (`mouse_mode_i`=1), a pin change from 0 to 1 that is set up before clock edge k makes `irq12_o` high after edge k+SYNC_STAGES (edge k+2 with two stages).
- R3: Once set in mouse mode, `irq12_o` stays high after the pin returns low.
- R4: A cycle with `io_rd_i`=1 and `io_addr_i`=0x060 clears the latch, so `irq12_o` is low after that edge unless R7 applies.
- R5: A cycle with `io_wr_i`=1 and `io_rd_i`=0 at address 0x060 leaves the latch unchanged.
- R6: A read of any address other than 0x060 leaves the latch unchanged.
- R7: If the latch-setting edge and a clearing read of 0x060 occur at the same clock edge, the latch ends up set.
- R8: A clock edge with `mouse_mode_i`=0 clears the latch. When mouse mode is selected again, `irq12_o` stays low until a new rising edge arrives.
- R9: In pass-through mode, `irq12_o` equals the pin level delayed by SYNC_STAGES clock edges.
- R10: A pin held high produces only one set event. After a clearing read, `irq12_o` stays low while the pin remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high bus reset |
| irq_pin_i | input | 1 | Asynchronous shared interrupt pin (pulled up) |
| mouse_mode_i | input | 1 | 1 selects mouse latch mode, 0 selects pass-through |
| io_rd_i | input | 1 | I/O read strobe, one cycle per access |
| io_wr_i | input | 1 | I/O write strobe, one cycle per access |
| io_addr_i | input | ADDR_W | I/O address qualified by the strobes |
| irq12_o | output | 1 | IRQ12 request to the interrupt controller |

## Verification
The bench uses the default build: two synchronizer stages, a 16-bit address and data port 0x060. With these values the exact edge latency is only a few cycles, so the directed checks can count clock edges one by one. In the long sweep, addresses are drawn from a small set around 0x060: the port itself, neighbouring addresses, and 0x160, which matches 0x060 in the low byte. Reads, writes, mode flips and pin toggles are mixed so that set, clear, collision and mode-exit cases occur together many times. An independent cycle model compares against every cycle.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

    typedef enum logic {
        IRQ_PASS  = 1'b0,
        IRQ_MOUSE = 1'b1
    } irq_mode_e;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_DATA_RD = 2'd1,
        ACC_DATA_WR = 2'd2,
        ACC_OTHER   = 2'd3
    } io_acc_e;

    typedef struct packed {
        logic level;
        logic rise;
    } pin_evt_t;

    function automatic io_acc_e classify_access(input logic rd, input logic wr,
                                                input logic port_hit);
        io_acc_e acc;
        if (rd && port_hit)      acc = ACC_DATA_RD;
        else if (wr && port_hit) acc = ACC_DATA_WR;
        else if (rd || wr)       acc = ACC_OTHER;
        else                     acc = ACC_NONE;
        return acc;
    endfunction

    function automatic logic next_latch(input irq_mode_e mode, input logic rise,
                                        input io_acc_e acc, input logic cur);
        logic nxt;
        if (mode == IRQ_PASS)         nxt = 1'b0;
        else if (rise)                nxt = 1'b1;
        else if (acc == ACC_DATA_RD)  nxt = 1'b0;
        else                          nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/mirq_sync.sv
module mirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= 1'b1;
                end else begin
                    if (g == 0) chain[g] <= d_i;
                    else        chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mirq_edge.sv
module mirq_edge
    import mirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     level_i,
    output pin_evt_t evt_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level_i;
    end

    always_comb begin
        evt_o.level = level_i;
        evt_o.rise  = level_i & ~prev_q;
    end
endmodule

// File: rtl/mirq_io_decode.sv
module mirq_io_decode
    import mirq_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h060
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output io_acc_e           acc_o
);
    logic hit;

    always_comb begin
        hit   = (addr_i == DATA_PORT);
        acc_o = classify_access(rd_i, wr_i, hit);
    end
endmodule

// File: rtl/mirq_latch.sv
module mirq_latch
    import mirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode_i,
    input  logic      rise_i,
    input  io_acc_e   acc_i,
    output logic      q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= next_latch(mode_i, rise_i, acc_i, q);
    end

    assign q_o = q;
endmodule

// File: rtl/mouse_irq_latch.sv
module mouse_irq_latch
    import mirq_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT   = 'h060
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_i,
    input  logic              mouse_mode_i,
    input  logic              io_rd_i,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    output logic              irq12_o
);
    localparam int unsigned STG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    irq_mode_e mode;
    logic      pin_sync;
    pin_evt_t  evt;
    io_acc_e   acc;
    logic      clr_w;
    logic      latch_q;

    assign mode  = irq_mode_e'(mouse_mode_i);
    assign clr_w = (acc == ACC_DATA_RD);

    mirq_sync #(.STAGES(STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (irq_pin_i),
        .q_o (pin_sync)
    );

    mirq_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (pin_sync),
        .evt_o   (evt)
    );

    mirq_io_decode #(.ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT)) u_dec (
        .rd_i   (io_rd_i),
        .wr_i   (io_wr_i),
        .addr_i (io_addr_i),
        .acc_o  (acc)
    );

    mirq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .rise_i (evt.rise),
        .acc_i  (acc),
        .q_o    (latch_q)
    );

    always_comb begin
        unique case (mode)
            IRQ_MOUSE: irq12_o = latch_q;
            default:   irq12_o = evt.level;
        endcase
    end
endmodule

// File: rtl/mirq_chk.sv
module mirq_chk (
    input logic clk,
    input logic rst,
    input logic mode,
    input logic irq,
    input logic rise,
    input logic clr
);
    // R1
    reset_low_chk: assert property (@(posedge clk)
        $past(rst) && mode |-> !irq);

    // R2
    set_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        mode && rise |=> (irq || !mode));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mode && irq && !clr |=> (irq || !mode));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode && clr && !rise |=> (!irq || !mode));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        mode && clr && rise |=> (irq || !mode));

    // R8
    reentry_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode) |-> !irq);
endmodule

bind mouse_irq_latch mirq_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .mode (mouse_mode_i),
    .irq  (irq12_o),
    .rise (evt.rise),
    .clr  (clr_w)
);

// File: tb/mouse_irq_latch_tb.sv
module mouse_irq_latch_tb;
    localparam int unsigned S    = 2;
    localparam logic [15:0] PORT = 16'h0060;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b1;
    logic        mode = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic m_pipe [S];
    logic m_prev;
    logic m_lat;

    always #2 clk = ~clk;

    mouse_irq_latch u_dut (
        .clk          (clk),
        .rst          (rst),
        .irq_pin_i    (pin),
        .mouse_mode_i (mode),
        .io_rd_i      (rd),
        .io_wr_i      (wr),
        .io_addr_i    (addr),
        .irq12_o      (irq)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: irq12 got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic rise;
        if (rst) begin
            for (int i = 0; i < S; i++) m_pipe[i] = 1'b1;
            m_prev = 1'b1;
            m_lat  = 1'b0;
        end else begin
            rise = m_pipe[S-1] & ~m_prev;
            if (!mode)                      m_lat = 1'b0;
            else if (rise)                  m_lat = 1'b1;
            else if (rd && addr == PORT)    m_lat = 1'b0;
            m_prev = m_pipe[S-1];
            for (int i = S-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = pin;
        end
    endtask

    // Called at a negative edge: apply inputs, clock once, compare with model.
    task automatic step(input logic r, input logic p, input logic m,
                        input logic rdi, input logic wri, input logic [15:0] a,
                        input string tag);
        rst = r; pin = p; mode = m; rd = rdi; wr = wri; addr = a;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, irq, mode ? m_lat : m_pipe[S-1]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [15:0] addrs [5];
        addrs[0] = 16'h0060; addrs[1] = 16'h0061; addrs[2] = 16'h0064;
        addrs[3] = 16'h0160; addrs[4] = 16'h00E0;
        @(negedge clk);

        // R1: reset in mouse mode with pin floating high
        step(1, 1, 1, 0, 0, 0, "R1 reset");
        step(1, 1, 1, 0, 0, 0, "R1 reset");
        chk("R1 reset low", irq, 1'b0);
        step(0, 1, 1, 0, 0, 0, "R1 no false edge");
        step(0, 1, 1, 0, 0, 0, "R1 no false edge");
        chk("R1 no false edge", irq, 1'b0);

        // R2: latency of a rising edge
        step(0, 0, 1, 0, 0, 0, "R2 pin low");
        step(0, 0, 1, 0, 0, 0, "R2 pin low");
        step(0, 0, 1, 0, 0, 0, "R2 pin low");
        step(0, 1, 1, 0, 0, 0, "R2 edge k");
        chk("R2 after k", irq, 1'b0);
        step(0, 1, 1, 0, 0, 0, "R2 edge k+1");
        chk("R2 after k+1", irq, 1'b0);
        step(0, 1, 1, 0, 0, 0, "R2 edge k+2");
        chk("R2 after k+2", irq, 1'b1);

        // R3: sticky after pin falls
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R3 sticky");
        chk("R3 sticky", irq, 1'b1);

        // R5: write to data port ignored
        step(0, 0, 1, 0, 1, PORT, "R5 write 0x060");
        chk("R5 write 0x060", irq, 1'b1);
        // R6: reads elsewhere ignored
        step(0, 0, 1, 1, 0, 16'h0064, "R6 read 0x064");
        step(0, 0, 1, 1, 0, 16'h0160, "R6 read 0x160");
        chk("R6 other reads", irq, 1'b1);
        // R4: clearing read
        step(0, 0, 1, 1, 0, PORT, "R4 read 0x060");
        chk("R4 cleared", irq, 1'b0);

        // R10: level held high gives one event
        step(0, 1, 1, 0, 0, 0, "R10 rise");
        step(0, 1, 1, 0, 0, 0, "R10 rise");
        step(0, 1, 1, 0, 0, 0, "R10 rise");
        chk("R10 set", irq, 1'b1);
        step(0, 1, 1, 1, 0, PORT, "R10 clear");
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 0, "R10 held high");
        chk("R10 held high stays low", irq, 1'b0);

        // R7: set and clear at the same edge
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 0, "R7 prep");
        step(0, 1, 1, 0, 0, 0, "R7 edge k");
        step(0, 1, 1, 0, 0, 0, "R7 edge k+1");
        step(0, 1, 1, 1, 0, PORT, "R7 collide");
        chk("R7 set wins", irq, 1'b1);

        // R8: leaving mouse mode clears the latch
        step(0, 1, 0, 0, 0, 0, "R8 exit");
        step(0, 1, 1, 0, 0, 0, "R8 reentry");
        chk("R8 reentry low", irq, 1'b0);

        // R9: pass-through follows pin with S edges delay
        step(0, 0, 0, 0, 0, 0, "R9 low k");
        chk("R9 after k", irq, 1'b1);
        step(0, 0, 0, 0, 0, 0, "R9 low k+1");
        chk("R9 after k+1", irq, 1'b0);
        step(0, 1, 0, 1, 0, PORT, "R9 read ignored");
        step(0, 1, 0, 0, 0, 0, "R9 high");
        chk("R9 follows high", irq, 1'b1);

        // Sweep: R2 R3 R4 R5 R6 R7 R8 R9 mixed, checked against the model
        lfsr = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            logic p, m, r, w, rs;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p  = lfsr[0] ^ lfsr[7];
            m  = (lfsr[3:1] != 3'd0);
            r  = lfsr[4];
            w  = lfsr[5] & ~lfsr[4];
            rs = (lfsr[15:8] == 8'h5A);
            step(rs, p, m, r, w, addrs[lfsr[11:9] % 5], "R2-R9 sweep");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule